// File: doc/BRIEF.md
# Two-Wire Bus Master Clock Generator

This block produces the serial clock of a two-wire bus master, together with the data-line timing for start and stop conditions. It works from the peripheral clock and a programmable baud value. Both lines are open-drain: the block either pulls a line low or releases it. It reads the real clock-line level back from the bus through a two-flop synchronizer. Each clock phase lasts 5 + baud peripheral cycles. The high phase counts only from the moment the synchronized line reads high, so a slow rise stretches the period rather than eating into the high time. When fast-mode-plus is selected, baud values below 3 are clamped to 3 and a sticky error flag is raised.

A controller drives it with four commands: start, repeated start, clock one bit, and stop. After a start the block parks with the clock held low. It accepts the next command at a bit boundary. The block releases the data line while bits are clocked, so external data logic combines its own low drive with the data output. A one-cycle strobe marks the end of each high phase, where that logic samples the data line.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset both lines are released and `busy`, `bit_strobe` and `config_error` are 0, while `cmd_ready` is 1.
- R2: The phase length is P = 5 + B peripheral cycles, where B is the effective baud value. When the next bit command is presented by the time `cmd_ready` rises, the clock stays low for exactly P cycles between bits.
- R3: After the clock is released, the high count starts only once the synchronized level reads high. The clock stays released for rise + P + 3 cycles (two synchronizer stages plus one detect cycle), and the line reads high for P + 3 of those cycles whatever the rise delay.
- R4: A start pulls the data line low with the clock released for P cycles (start hold). The clock then goes low for P cycles while the data line is still held low.
- R5: A stop has three stages. First the clock is held low for P cycles with the data line low. Then the clock is released with the data line still low for rise + P + 3 cycles (stop setup). Then the data line is released, and a bus-free interval of P cycles follows in which `busy` is 1 and `cmd_ready` is 0. After that `busy` drops.
- R6: A repeated start has three stages. First the clock is held low for P cycles with the data line released. Then the clock is released with the data line released for rise + P + 3 cycles (repeated-start setup). Then the start hold of R4 follows.
- R7: `bit_strobe` pulses exactly once per clocked bit, in the last cycle of the high phase, while the clock is released.
- R8: While idle, every command except start is ignored: both lines stay released and `busy` stays 0.
- R9: When `fm_plus` is 1 and `baud` is below 3, the effective value B is 3, and `config_error` becomes 1 and stays 1 until reset. When `fm_plus` is 0, B equals `baud` and no error is raised.
- R10: Command codes on `cmd` are 0 start, 1 repeated start, 2 bit, and 3 stop. A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high while idle, while parked, and in the last cycle of each low phase. A start issued inside a transaction acts as a repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud | input | BAUD_W | Programmed baud value |
| fm_plus | input | 1 | Fast-mode-plus select (enforces the minimum baud) |
| cmd_valid | input | 1 | Command present |
| cmd | input | 2 | Command code (see R10) |
| cmd_ready | output | 1 | Command can be taken this cycle |
| scl_in | input | 1 | Clock-line level sensed from the bus |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Transaction in progress, including bus-free time |
| bit_strobe | output | 1 | One-cycle pulse at the end of each high phase |
| config_error | output | 1 | Sticky flag for an unsupported baud value in fast-mode-plus |

## Verification
Full frames are run with several baud values (0, 2 and 10) and with bus rise delays of 0, 3 and 5 cycles. The released time must grow with the rise delay while the observed high time stays fixed, which separates counting from the sensed level from counting from the release. Repeated start and stop are each placed after clocked bits, so their setup, hold and bus-free intervals are measured against each other. Fast-mode-plus runs use baud values below and above the minimum, which distinguishes clamping from passing the value through and shows that the error flag is sticky. Non-start commands are also sent while idle, to show that they are ignored.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int BAUD_W     = 8,
  parameter int PHASE_BASE = 5,
  parameter int FMP_MIN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAUD_W-1:0] baud,
  input  logic              fm_plus,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd,
  output logic              cmd_ready,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              busy,
  output logic              bit_strobe,
  output logic              config_error
);

  localparam int CW = BAUD_W + 2;
  localparam logic [1:0] CMD_START = 2'd0;
  localparam logic [1:0] CMD_BIT   = 2'd2;
  localparam logic [1:0] CMD_STOP  = 2'd3;

  typedef enum logic [3:0] {
    IDLE, ST_HOLD, ST_LOW, PARK, BIT_RISE, BIT_HIGH, BIT_LOW,
    RS_LOW, RS_RISE, RS_SETUP, P_LOW, P_RISE, P_SETUP, FREE
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic load, done, too_low;
  logic scl_meta, scl_seen;
  logic [BAUD_W-1:0] eff_baud;
  logic [CW-1:0] load_val;

  assign too_low  = fm_plus && (baud < BAUD_W'(FMP_MIN));
  assign eff_baud = too_low ? BAUD_W'(FMP_MIN) : baud;
  assign load_val = CW'(eff_baud) + CW'(PHASE_BASE - 1);
  assign done     = (cnt == '0);

  assign scl_drive_low = st inside {ST_LOW, PARK, BIT_LOW, RS_LOW, P_LOW};
  assign sda_drive_low = st inside {ST_HOLD, ST_LOW, P_LOW, P_RISE, P_SETUP};
  assign busy          = (st != IDLE);
  assign bit_strobe    = (st == BIT_HIGH) && done;
  assign cmd_ready     = (st == IDLE) || (st == PARK) ||
                         (((st == ST_LOW) || (st == BIT_LOW)) && done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_meta <= 1'b1;
      scl_seen <= 1'b1;
    end else begin
      scl_meta <= scl_in;
      scl_seen <= scl_meta;
    end
  end

  always_comb begin
    nxt  = st;
    load = 1'b0;
    case (st)
      IDLE:
        if (cmd_valid && cmd == CMD_START) begin nxt = ST_HOLD; load = 1'b1; end
      ST_HOLD:
        if (done) begin nxt = ST_LOW; load = 1'b1; end
      ST_LOW, BIT_LOW, PARK:
        if (cmd_valid && cmd_ready) begin
          case (cmd)
            CMD_BIT:  nxt = BIT_RISE;
            CMD_STOP: begin nxt = P_LOW;  load = 1'b1; end
            default:  begin nxt = RS_LOW; load = 1'b1; end
          endcase
        end else if (done && st != PARK) begin
          nxt = PARK;
        end
      BIT_RISE:
        if (scl_seen) begin nxt = BIT_HIGH; load = 1'b1; end
      BIT_HIGH:
        if (done) begin nxt = BIT_LOW; load = 1'b1; end
      RS_LOW:
        if (done) nxt = RS_RISE;
      RS_RISE:
        if (scl_seen) begin nxt = RS_SETUP; load = 1'b1; end
      RS_SETUP:
        if (done) begin nxt = ST_HOLD; load = 1'b1; end
      P_LOW:
        if (done) nxt = P_RISE;
      P_RISE:
        if (scl_seen) begin nxt = P_SETUP; load = 1'b1; end
      P_SETUP:
        if (done) begin nxt = FREE; load = 1'b1; end
      FREE:
        if (done) nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      cnt          <= '0;
      config_error <= 1'b0;
    end else begin
      st <= nxt;
      if (load)       cnt <= load_val;
      else if (!done) cnt <= cnt - 1'b1;
      if (too_low) config_error <= 1'b1;
    end
  end

  assert_wait_sensed_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BIT_RISE && !scl_seen) |=> (st != BIT_HIGH));

  assert_strobe_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (!scl_drive_low && scl_seen));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);

  assert_fmp_min_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_plus && load) |=> (cnt >= CW'(FMP_MIN + PHASE_BASE - 1)));

  assert_lines_free_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_drive_low && !sda_drive_low));

endmodule

// File: tb/i2c_scl_gen_tb.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] baud = 8'd2;
  logic fm_plus = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic cmd_ready, scl_drive_low, sda_drive_low, busy, bit_strobe, config_error;
  logic scl_line;
  int rise_cyc = 0;
  int rel = 0;
  int checks = 0;
  int fails = 0;
  int last_low = 0;
  int run_len = 0;
  logic prev_scl = 1'b0;

  always #5 clk = ~clk;

  i2c_scl_gen #(.BAUD_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud(baud), .fm_plus(fm_plus),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_ready(cmd_ready),
    .scl_in(scl_line), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .bit_strobe(bit_strobe), .config_error(config_error)
  );

  always @(posedge clk) begin
    if (scl_drive_low) rel <= 0;
    else if (rel < rise_cyc) rel <= rel + 1;
  end
  assign scl_line = !scl_drive_low && (rel >= rise_cyc);

  always @(negedge clk) begin
    if (scl_drive_low != prev_scl) begin
      if (prev_scl) last_low = run_len;
      run_len = 1;
    end else begin
      run_len++;
    end
    prev_scl = scl_drive_low;
  end

  function automatic int nph(int b, bit f);
    return 5 + ((f && b < 3) ? 3 : b);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic send(logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(!scl_drive_low && !sda_drive_low && !busy && cmd_ready && !bit_strobe && !config_error,
        "R1 reset state", {scl_drive_low, sda_drive_low, busy, cmd_ready, bit_strobe, config_error}, 6'b000100);
  endtask

  task automatic t_idle_ignore();
    for (int c = 1; c < 4; c++) begin
      int bad = 0;
      send(2'(c));
      repeat (4) begin
        if (busy || scl_drive_low || sda_drive_low) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 idle ignores command", bad, 0);
    end
  endtask

  task automatic start_seq(int n);
    int k = 0;
    chk(cmd_ready && !busy, "R10 ready while idle", cmd_ready, 1);
    send(2'd0);
    while (sda_drive_low && !scl_drive_low) begin k++; @(negedge clk); end
    chk(k == n, "R4 start hold", k, n);
    chk(sda_drive_low && scl_drive_low && busy, "R4 data held in first low", sda_drive_low, 1);
  endtask

  task automatic do_bit(int n);
    int rel_n = 0, hi_n = 0, sb = 0;
    send(2'd2);
    while (!scl_drive_low) begin
      rel_n++;
      if (scl_line) hi_n++;
      if (bit_strobe) sb++;
      @(negedge clk);
    end
    chk(rel_n == rise_cyc + n + 3, "R3 released time", rel_n, rise_cyc + n + 3);
    chk(hi_n == n + 3, "R3 high time", hi_n, n + 3);
    chk(sb == 1, "R7 one strobe", sb, 1);
    chk(last_low == n, "R2 low phase", last_low, n);
  endtask

  task automatic stop_seq(int n);
    int k = 0, bad = 0;
    send(2'd3);
    while (scl_drive_low) begin if (!sda_drive_low) bad++; k++; @(negedge clk); end
    chk(k == n && bad == 0, "R5 stop low phase", k, n);
    k = 0;
    while (!scl_drive_low && sda_drive_low) begin k++; @(negedge clk); end
    chk(k == rise_cyc + n + 3, "R5 stop setup", k, rise_cyc + n + 3);
    k = 0; bad = 0;
    while (busy) begin
      if (cmd_ready || sda_drive_low || scl_drive_low) bad++;
      k++;
      @(negedge clk);
    end
    chk(k == n, "R5 bus free", k, n);
    chk(bad == 0, "R5 not ready during bus free", bad, 0);
    chk(cmd_ready && !busy, "R5 idle after stop", busy, 0);
  endtask

  task automatic rstart_seq(int n);
    int k = 0, bad = 0;
    send(2'd1);
    while (scl_drive_low) begin if (sda_drive_low) bad++; k++; @(negedge clk); end
    chk(k == n && bad == 0, "R6 repeated start low", k, n);
    k = 0;
    while (!scl_drive_low && !sda_drive_low) begin k++; @(negedge clk); end
    chk(k == rise_cyc + n + 3, "R6 repeated start setup", k, rise_cyc + n + 3);
    k = 0;
    while (sda_drive_low && !scl_drive_low) begin k++; @(negedge clk); end
    chk(k == n, "R6 repeated start hold", k, n);
  endtask

  task automatic t_frame(int b, bit f, int r, int nbits);
    int n;
    baud = 8'(b);
    fm_plus = f;
    rise_cyc = r;
    n = nph(b, f);
    repeat (2) @(negedge clk);
    start_seq(n);
    repeat (nbits) do_bit(n);
    stop_seq(n);
  endtask

  task automatic t_rstart();
    int n = nph(3, 1'b0);
    baud = 8'd3; fm_plus = 1'b0; rise_cyc = 3;
    repeat (2) @(negedge clk);
    start_seq(n);
    do_bit(n);
    rstart_seq(n);
    do_bit(n);
    stop_seq(n);
  endtask

  task automatic t_fmplus();
    baud = 8'd0; fm_plus = 1'b0;
    repeat (3) @(negedge clk);
    chk(!config_error, "R9 no error in standard mode", config_error, 0);
    baud = 8'd1; fm_plus = 1'b1;
    repeat (2) @(negedge clk);
    chk(config_error, "R9 error raised", config_error, 1);
    t_frame(1, 1'b1, 2, 1);
    t_frame(4, 1'b1, 0, 1);
    chk(config_error, "R9 error sticky", config_error, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_frame(2, 1'b0, 0, 2);
    t_frame(2, 1'b0, 5, 2);
    t_frame(0, 1'b0, 3, 1);
    t_frame(10, 1'b0, 0, 1);
    t_rstart();
    t_fmplus();
    finish_run();
  end
endmodule